// File: doc/BRIEF.md
# Precise Exception Sequencer

This block sits beside the completion stage of an in-order core and decides when an exception is taken. Execution units may report faults out of order, each tagged with the 4-bit sequence tag of the instruction that caused it. The block stores these reports and acts on a fault only when its instruction reaches the completion slot and finishes. So an older instruction always completes, or takes its own fault, before any younger fault is serviced.

An asynchronous precise request, such as an external interrupt, is latched the moment it arrives. It is serviced only at a safe point: the completed-store queue must report empty, and the completion slot must be either empty or holding an instruction that finishes without a fault. When either kind of exception is taken, the block captures a program counter, the prior machine state and a full cause code. It raises the supervisor flag, flushes every stored fault and pulses a redirect with a vector address for one clock. Vectors are shared per cause class, and the cause register keeps the detailed code.

Top module: `precise_exc_seq`

## Requirements
- R1: After a synchronous reset, redirect, redirect address, saved PC, saved state and cause are all zero. The supervisor flag, the interrupt enable, the pending interrupt and all stored faults are cleared, and the oldest tag is 0.
- R2: When the instruction in the completion slot finishes (slot_occ=1, slot_fin=1) with a fault recorded for its tag, the exception is taken. The fault may be recorded in an earlier cycle or in the same cycle. One clock later, redirect=1, save_pc equals slot_pc and cause equals the reported code.
- R3: A finishing instruction whose own tag has no recorded fault retires normally, with no redirect, even if faults are recorded for younger tags.
- R4: Age is counted from the oldest unfinished tag, modulo 16. After a finish, the oldest tag becomes the finishing tag plus 1, so tag 15 is older than tag 0 when the oldest tag is 14.
- R5: Taking any exception discards every recorded fault, including faults reported in that same cycle.
- R6: A latched asynchronous request with its enable set is taken only when sq_empty=1 and the slot is either empty or finishing without a fault. save_pc then equals resume_pc, and cause is 5'd20 (class 5, detail 0).
- R7: If a synchronous fault is taken in the same cycle that an asynchronous request is ready, the fault wins and the request stays pending.
- R8: With the enable clear, an asynchronous request stays pending and is not taken. ext_en_set sets the enable. Taking an asynchronous exception clears the enable in the same update.
- R9: redirect_pc equals vec_base + (cause[4:2] << 8). The cause class is bits [4:2] and the detail is bits [1:0]. Class 5 is reserved for asynchronous requests. The cause output and redirect_pc hold their values between exceptions.
- R10: On an exception, save_state receives {30'b0, enable, supervisor} as they were before the exception, and the supervisor flag becomes 1.
- R11: redirect is high for exactly the one clock that follows each taken exception.
- R12: A resume pulse restores the supervisor flag from save_state[0] and the enable from save_state[1]. If an exception is taken in the same cycle, the resume pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_occ | input | 1 | An instruction occupies the completion slot |
| slot_fin | input | 1 | The slot instruction finishes this cycle |
| slot_tag | input | 4 | Sequence tag of the slot instruction |
| slot_pc | input | 32 | PC of the slot instruction |
| resume_pc | input | 32 | Address execution would continue at after this cycle |
| flt_vld | input | 1 | A fault report is present |
| flt_tag | input | 4 | Tag of the faulting instruction |
| flt_code | input | 5 | Cause code of the fault (class, detail) |
| ext_req | input | 1 | Asynchronous precise request pulse |
| ext_en_set | input | 1 | Sets the asynchronous request enable |
| sq_empty | input | 1 | Completed-store queue is empty |
| resume | input | 1 | Return from exception: restore saved flags |
| vec_base | input | 32 | Vector base address |
| redirect | output | 1 | One-clock fetch redirect pulse |
| redirect_pc | output | 32 | Vector address of the last exception |
| save_pc | output | 32 | Saved program counter |
| save_state | output | 32 | Saved prior machine state |
| cause | output | 5 | Cause code of the last exception |
| sup_mode | output | 1 | Supervisor flag |
| ext_en | output | 1 | Asynchronous request enable |

## Verification
Every result is registered once. A fault, finish or request presented before clock edge k appears on redirect and on the save, cause and vector outputs just after edge k. A resume or enable pulse shows on sup_mode and ext_en at the same point. An interrupt released by a sync fault in the same cycle arrives one edge later. The bench drives inputs on falling edges and keeps a behavioural model that advances on rising edges. It compares all outputs at the next falling edge, so each expectation lands in the cycle of its register. Directed checks after each scenario confirm wrap-around age, flushing, deferral and priority.

// File: rtl/pes_pkg.sv
package pes_pkg;
  localparam int TAG_W       = 4;
  localparam int CLS_W       = 3;
  localparam int SUB_W       = 2;
  localparam int CODE_W      = CLS_W + SUB_W;
  localparam int XLEN        = 32;
  localparam int VEC_SHIFT   = 8;
  localparam int ASYNC_CLASS = 5;
endpackage

// File: rtl/pes_fault_table.sv
module pes_fault_table #(
  parameter int TAG_W  = pes_pkg::TAG_W,
  parameter int CODE_W = pes_pkg::CODE_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   flush,
  input  logic                   wr_en,
  input  logic [TAG_W-1:0]       wr_tag,
  input  logic [CODE_W-1:0]      wr_code,
  input  logic                   clr_en,
  input  logic [TAG_W-1:0]       clr_tag,
  input  logic [TAG_W-1:0]       rd_tag,
  output logic [(1<<TAG_W)-1:0]  pend,
  output logic [CODE_W-1:0]      rd_code
);
  localparam int DEPTH = 1 << TAG_W;

  logic [DEPTH-1:0]  pend_q;
  logic [CODE_W-1:0] code_q [DEPTH];
  logic              accept;

  // first report for a tag wins; later duplicates are dropped
  assign accept = wr_en && !pend_q[wr_tag];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      pend_q <= '0;
    end else begin
      if (accept) pend_q[wr_tag] <= 1'b1;
      if (clr_en) pend_q[clr_tag] <= 1'b0;
    end
  end

  // storage without reset so it maps to distributed RAM
  always_ff @(posedge clk) begin
    if (accept) code_q[wr_tag] <= wr_code;
  end

  assign pend    = pend_q;
  assign rd_code = code_q[rd_tag];
endmodule

// File: rtl/pes_oldest_pick.sv
module pes_oldest_pick #(
  parameter int TAG_W = pes_pkg::TAG_W
) (
  input  logic [TAG_W-1:0]       head,
  input  logic [(1<<TAG_W)-1:0]  vec,
  output logic                   found,
  output logic [TAG_W-1:0]       tag
);
  localparam int DEPTH = 1 << TAG_W;

  logic [DEPTH-1:0] rot;

  // rot[a] is the entry that is a slots younger than head
  for (genvar g = 0; g < DEPTH; g++) begin : g_rot
    localparam logic [TAG_W-1:0] OFS = TAG_W'(g);
    assign rot[g] = vec[head + OFS];
  end

  always_comb begin
    found = |rot;
    tag   = head;
    for (int a = DEPTH - 1; a >= 0; a--) begin
      if (rot[a]) tag = head + TAG_W'(a);
    end
  end
endmodule

// File: rtl/pes_take_arbiter.sv
module pes_take_arbiter #(
  parameter int TAG_W = pes_pkg::TAG_W
) (
  input  logic             slot_occ,
  input  logic             slot_fin,
  input  logic [TAG_W-1:0] slot_tag,
  input  logic             sel_found,
  input  logic [TAG_W-1:0] sel_tag,
  input  logic             async_pend,
  input  logic             async_en,
  input  logic             sq_empty,
  output logic             finishing,
  output logic             take_sync,
  output logic             take_async
);
  logic safe_pt;

  assign finishing  = slot_occ && slot_fin;
  assign take_sync  = finishing && sel_found && (sel_tag == slot_tag);
  assign safe_pt    = sq_empty && (!slot_occ || (finishing && !take_sync));
  assign take_async = !take_sync && async_pend && async_en && safe_pt;
endmodule

// File: rtl/precise_exc_seq.sv
module precise_exc_seq #(
  parameter int TAG_W       = pes_pkg::TAG_W,
  parameter int CLS_W       = pes_pkg::CLS_W,
  parameter int SUB_W       = pes_pkg::SUB_W,
  parameter int XLEN        = pes_pkg::XLEN,
  parameter int VEC_SHIFT   = pes_pkg::VEC_SHIFT,
  parameter int ASYNC_CLASS = pes_pkg::ASYNC_CLASS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    slot_occ,
  input  logic                    slot_fin,
  input  logic [TAG_W-1:0]        slot_tag,
  input  logic [XLEN-1:0]         slot_pc,
  input  logic [XLEN-1:0]         resume_pc,
  input  logic                    flt_vld,
  input  logic [TAG_W-1:0]        flt_tag,
  input  logic [CLS_W+SUB_W-1:0]  flt_code,
  input  logic                    ext_req,
  input  logic                    ext_en_set,
  input  logic                    sq_empty,
  input  logic                    resume,
  input  logic [XLEN-1:0]         vec_base,
  output logic                    redirect,
  output logic [XLEN-1:0]         redirect_pc,
  output logic [XLEN-1:0]         save_pc,
  output logic [XLEN-1:0]         save_state,
  output logic [CLS_W+SUB_W-1:0]  cause,
  output logic                    sup_mode,
  output logic                    ext_en
);
  localparam int CODE_W = CLS_W + SUB_W;
  localparam int DEPTH  = 1 << TAG_W;
  localparam logic [CODE_W-1:0] ASYNC_CODE = {CLS_W'(ASYNC_CLASS), SUB_W'(0)};

  logic [TAG_W-1:0]  head_q;
  logic              irq_pend_q;
  logic [DEPTH-1:0]  tbl_pend, merged, flt_onehot;
  logic [CODE_W-1:0] tbl_code, sel_code, take_code;
  logic              sel_found, finishing, take_sync, take_async, take;
  logic [TAG_W-1:0]  sel_tag;
  logic [XLEN-1:0]   vec_next;

  pes_fault_table #(.TAG_W(TAG_W), .CODE_W(CODE_W)) u_tbl (
    .clk     (clk),
    .rst     (rst),
    .flush   (take),
    .wr_en   (flt_vld),
    .wr_tag  (flt_tag),
    .wr_code (flt_code),
    .clr_en  (finishing),
    .clr_tag (slot_tag),
    .rd_tag  (sel_tag),
    .pend    (tbl_pend),
    .rd_code (tbl_code)
  );

  // a report arriving this cycle joins the search at once
  assign flt_onehot = flt_vld ? (DEPTH'(1) << flt_tag) : '0;
  assign merged     = tbl_pend | flt_onehot;

  pes_oldest_pick #(.TAG_W(TAG_W)) u_pick (
    .head  (head_q),
    .vec   (merged),
    .found (sel_found),
    .tag   (sel_tag)
  );

  assign sel_code = (flt_vld && (flt_tag == sel_tag) && !tbl_pend[sel_tag])
                    ? flt_code : tbl_code;

  pes_take_arbiter #(.TAG_W(TAG_W)) u_arb (
    .slot_occ   (slot_occ),
    .slot_fin   (slot_fin),
    .slot_tag   (slot_tag),
    .sel_found  (sel_found),
    .sel_tag    (sel_tag),
    .async_pend (irq_pend_q),
    .async_en   (ext_en),
    .sq_empty   (sq_empty),
    .finishing  (finishing),
    .take_sync  (take_sync),
    .take_async (take_async)
  );

  assign take      = take_sync || take_async;
  assign take_code = take_sync ? sel_code : ASYNC_CODE;
  assign vec_next  = vec_base + (XLEN'(take_code[CODE_W-1:SUB_W]) << VEC_SHIFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect    <= 1'b0;
      redirect_pc <= '0;
      save_pc     <= '0;
      save_state  <= '0;
      cause       <= '0;
      sup_mode    <= 1'b0;
      ext_en      <= 1'b0;
      irq_pend_q  <= 1'b0;
      head_q      <= '0;
    end else begin
      redirect <= take;
      if (take) begin
        redirect_pc <= vec_next;
        save_pc     <= take_sync ? slot_pc : resume_pc;
        save_state  <= {{(XLEN-2){1'b0}}, ext_en, sup_mode};
        cause       <= take_code;
        sup_mode    <= 1'b1;
      end else if (resume) begin
        sup_mode    <= save_state[0];
      end

      if (take_async)             ext_en <= 1'b0;
      else if (resume && !take)   ext_en <= save_state[1];
      else if (ext_en_set)        ext_en <= 1'b1;

      irq_pend_q <= (irq_pend_q && !take_async) || ext_req;

      if (finishing) head_q <= slot_tag + TAG_W'(1);
    end
  end
endmodule

// File: rtl/pes_checker.sv
module pes_checker #(
  parameter int XLEN        = pes_pkg::XLEN,
  parameter int CODE_W      = pes_pkg::CODE_W,
  parameter int CLS_W       = pes_pkg::CLS_W,
  parameter int SUB_W       = pes_pkg::SUB_W,
  parameter int VEC_SHIFT   = pes_pkg::VEC_SHIFT,
  parameter int ASYNC_CLASS = pes_pkg::ASYNC_CLASS
) (
  input logic              clk,
  input logic              rst,
  input logic              redirect,
  input logic [XLEN-1:0]   redirect_pc,
  input logic [XLEN-1:0]   vec_base,
  input logic [CODE_W-1:0] cause,
  input logic [XLEN-1:0]   save_state,
  input logic              sup_mode,
  input logic              ext_en,
  input logic              ext_en_set,
  input logic              resume,
  input logic              sq_empty,
  input logic              slot_occ,
  input logic              slot_fin
);
  localparam logic [CODE_W-1:0] ACODE = {CLS_W'(ASYNC_CLASS), SUB_W'(0)};

  assert_priv_on_take_R10: assert property (@(posedge clk) disable iff (rst)
    redirect |-> sup_mode);

  assert_state_upper_zero_R10: assert property (@(posedge clk) disable iff (rst)
    redirect |-> (save_state[XLEN-1:2] == '0));

  assert_async_clears_en_R8: assert property (@(posedge clk) disable iff (rst)
    (redirect && cause == ACODE) |-> !ext_en);

  assert_async_drained_R6: assert property (@(posedge clk) disable iff (rst)
    (redirect && cause == ACODE) |-> $past(sq_empty));

  assert_sync_at_finish_R2: assert property (@(posedge clk) disable iff (rst)
    (redirect && cause != ACODE) |-> $past(slot_occ && slot_fin));

  assert_vec_align_R9: assert property (@(posedge clk) disable iff (rst)
    redirect |-> (redirect_pc[VEC_SHIFT-1:0] == $past(vec_base[VEC_SHIFT-1:0])));

  assert_cause_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !redirect |-> $stable(cause));

  assert_en_source_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(ext_en) |-> $past(ext_en_set || resume));
endmodule

bind precise_exc_seq pes_checker #(
  .XLEN(XLEN), .CODE_W(CLS_W + SUB_W), .CLS_W(CLS_W), .SUB_W(SUB_W),
  .VEC_SHIFT(VEC_SHIFT), .ASYNC_CLASS(ASYNC_CLASS)
) u_chk (
  .clk(clk), .rst(rst), .redirect(redirect), .redirect_pc(redirect_pc),
  .vec_base(vec_base), .cause(cause), .save_state(save_state),
  .sup_mode(sup_mode), .ext_en(ext_en), .ext_en_set(ext_en_set),
  .resume(resume), .sq_empty(sq_empty), .slot_occ(slot_occ),
  .slot_fin(slot_fin)
);

// File: tb/tb_precise_exc_seq.sv
module tb_precise_exc_seq;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic occ = 0, fin = 0, fv = 0, ireq = 0, iset = 0, sqe = 1, rsm = 0;
  logic [3:0]  stag = 0, ftag = 0;
  logic [4:0]  fcode = 0;
  logic [31:0] spc = 0, rpc = 0, base = 32'h8000_0000;

  logic        redirect, sup_mode, ext_en;
  logic [31:0] redirect_pc, save_pc, save_state;
  logic [4:0]  cause;

  precise_exc_seq dut (
    .clk(clk), .rst(rst), .slot_occ(occ), .slot_fin(fin), .slot_tag(stag),
    .slot_pc(spc), .resume_pc(rpc), .flt_vld(fv), .flt_tag(ftag),
    .flt_code(fcode), .ext_req(ireq), .ext_en_set(iset), .sq_empty(sqe),
    .resume(rsm), .vec_base(base), .redirect(redirect),
    .redirect_pc(redirect_pc), .save_pc(save_pc), .save_state(save_state),
    .cause(cause), .sup_mode(sup_mode), .ext_en(ext_en)
  );

  always #2 clk = ~clk;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  bit          m_fl[N];
  logic [4:0]  m_fc[N];
  bit          pv[N];
  logic [4:0]  pcd[N];
  int          m_head;
  bit          m_pend, m_en, m_sup, m_redir;
  logic [31:0] m_vec, m_epc, m_esr, oesr;
  logic [4:0]  m_cause, code;
  bit          found, mfin, syn, safe, asy, take;
  int          sel;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) m_fl[i] = 0;
      m_head = 0; m_pend = 0; m_en = 0; m_sup = 0; m_redir = 0;
      m_vec = 0; m_epc = 0; m_esr = 0; m_cause = 0;
    end else begin
      for (int i = 0; i < N; i++) begin pv[i] = m_fl[i]; pcd[i] = m_fc[i]; end
      if (fv && !pv[ftag]) begin pv[ftag] = 1; pcd[ftag] = fcode; end
      found = 0; sel = 0;
      for (int a = 0; a < N; a++) begin
        if (!found && pv[(m_head + a) % N]) begin found = 1; sel = (m_head + a) % N; end
      end
      mfin = occ && fin;
      syn  = mfin && found && (sel == int'(stag));
      safe = sqe && (!occ || (mfin && !syn));
      asy  = !syn && m_pend && m_en && safe;
      take = syn || asy;
      oesr = m_esr;
      m_redir = take;
      if (take) begin
        code    = syn ? pcd[sel] : 5'd20;
        m_cause = code;
        m_vec   = base + (32'(code >> 2) << 8);
        m_epc   = syn ? spc : rpc;
        m_esr   = {30'b0, m_en, m_sup};
        m_sup   = 1;
      end else if (rsm) m_sup = oesr[0];
      if (asy) m_en = 0;
      else if (rsm && !take) m_en = oesr[1];
      else if (iset) m_en = 1;
      m_pend = (m_pend && !asy) || ireq;
      if (take) begin
        for (int i = 0; i < N; i++) m_fl[i] = 0;
      end else begin
        if (fv && !m_fl[ftag]) begin m_fl[ftag] = 1; m_fc[ftag] = fcode; end
        if (mfin) m_fl[stag] = 0;
      end
      if (mfin) m_head = (int'(stag) + 1) % N;
    end
  end

  always @(negedge clk) begin
    chk(redirect == m_redir, "R11", "redirect", 32'(redirect), 32'(m_redir));
    chk(redirect_pc == m_vec, "R9", "redirect_pc", redirect_pc, m_vec);
    chk(save_pc == m_epc, "R2", "save_pc", save_pc, m_epc);
    chk(save_state == m_esr, "R10", "save_state", save_state, m_esr);
    chk(cause == m_cause, "R9", "cause", 32'(cause), 32'(m_cause));
    chk(sup_mode == m_sup, "R12", "sup_mode", 32'(sup_mode), 32'(m_sup));
    chk(ext_en == m_en, "R8", "ext_en", 32'(ext_en), 32'(m_en));
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fault(logic [3:0] t, logic [4:0] c);
    fv = 1; ftag = t; fcode = c; cyc(1); fv = 0;
  endtask

  task automatic finish(logic [3:0] t, logic [31:0] pc, logic [31:0] npc);
    occ = 1; fin = 1; stag = t; spc = pc; rpc = npc; cyc(1); occ = 0; fin = 0;
  endtask

  task automatic pulse_en();
    iset = 1; cyc(1); iset = 0;
  endtask

  initial begin
    cyc(4);
    rst = 0;
    cyc(1);
    chk(redirect == 0 && sup_mode == 0 && ext_en == 0 && cause == 0, "R1",
        "reset state", {redirect, sup_mode, ext_en, cause}, 32'h0);

    // R2: fault reported then finishing instruction takes it
    fault(4'd0, 5'd9);
    finish(4'd0, 32'h1000, 32'h1004);
    chk(redirect == 1, "R2", "redirect on fault", 32'(redirect), 32'h1);
    chk(save_pc == 32'h1000, "R2", "save_pc", save_pc, 32'h1000);
    chk(redirect_pc == 32'h8000_0200, "R9", "vector", redirect_pc, 32'h8000_0200);
    cyc(1);
    chk(redirect == 0, "R11", "pulse width", 32'(redirect), 32'h0);

    // R12: resume restores user mode
    rsm = 1; cyc(1); rsm = 0;
    chk(sup_mode == 0, "R12", "resume sup", 32'(sup_mode), 32'h0);

    // R3/R4/R5 across tag wrap
    for (int t = 1; t <= 13; t++) finish(4'(t), 32'h2000 + 32'(t * 4), 32'h2004 + 32'(t * 4));
    base = 32'h0001_0000;
    fault(4'd0, 5'd6);
    fault(4'd15, 5'd19);
    finish(4'd14, 32'h3000, 32'h3004);
    chk(redirect == 0, "R3", "older retires", 32'(redirect), 32'h0);
    finish(4'd15, 32'h3004, 32'h3008);
    chk(redirect == 1 && cause == 5'd19, "R4", "wrap oldest cause", 32'(cause), 32'd19);
    chk(redirect_pc == 32'h0001_0400, "R9", "vector class4", redirect_pc, 32'h0001_0400);
    finish(4'd0, 32'h3008, 32'h300c);
    chk(redirect == 0, "R5", "flushed fault ignored", 32'(redirect), 32'h0);

    // R6: deferral until drain and finish
    pulse_en();
    sqe = 0; occ = 1; fin = 0; stag = 4'd1;
    ireq = 1; cyc(1); ireq = 0;
    cyc(3);
    chk(redirect == 0, "R6", "held while queue busy", 32'(redirect), 32'h0);
    sqe = 1; cyc(2);
    chk(redirect == 0, "R6", "held while slot busy", 32'(redirect), 32'h0);
    finish(4'd1, 32'h4000, 32'h4008);
    chk(redirect == 1 && cause == 5'd20, "R6", "async taken", 32'(cause), 32'd20);
    chk(save_pc == 32'h4008, "R6", "async save_pc", save_pc, 32'h4008);

    // R6: empty slot, queue drains later
    pulse_en();
    sqe = 0; rpc = 32'h5000; ireq = 1; cyc(1); ireq = 0;
    cyc(2);
    chk(redirect == 0, "R6", "idle held", 32'(redirect), 32'h0);
    sqe = 1; cyc(1);
    chk(redirect == 1 && save_pc == 32'h5000, "R6", "idle take", save_pc, 32'h5000);

    // R7: sync beats ready async, then async next cycle
    pulse_en();
    sqe = 0; ireq = 1; cyc(1); ireq = 0;
    sqe = 1; fv = 1; ftag = 4'd2; fcode = 5'd10;
    occ = 1; fin = 1; stag = 4'd2; spc = 32'h6000; rpc = 32'h6004;
    cyc(1);
    fv = 0; occ = 0; fin = 0;
    chk(redirect == 1 && cause == 5'd10, "R7", "sync first", 32'(cause), 32'd10);
    cyc(1);
    chk(redirect == 1 && cause == 5'd20, "R7", "async after", 32'(cause), 32'd20);

    // R8: disabled request held
    ireq = 1; cyc(1); ireq = 0;
    cyc(4);
    chk(redirect == 0 && ext_en == 0, "R8", "held while disabled", 32'(redirect), 32'h0);
    pulse_en();
    chk(ext_en == 1 && redirect == 0, "R8", "enable set", 32'(ext_en), 32'h1);
    cyc(1);
    chk(redirect == 1 && ext_en == 0, "R8", "taken then cleared", 32'(ext_en), 32'h0);

    // R12: resume lost to exception in the same cycle
    fault(4'd3, 5'd5);
    rsm = 1; finish(4'd3, 32'h7000, 32'h7004); rsm = 0;
    chk(sup_mode == 1, "R12", "exception wins", 32'(sup_mode), 32'h1);
    rsm = 1; cyc(1); rsm = 0;
    chk(sup_mode == save_state[0], "R12", "restore", 32'(sup_mode), 32'(save_state[0]));
    cyc(3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule